// File: doc/BRIEF.md
# Reference Divider with Selectable Binary Taps

This block derives the comparison pulses for two phase-locked loops from one reference clock. A programmable counter divides the reference by R. A short binary post-scaler follows it and yields five candidate pulse streams: R, 2R, 4R, 8R and 16R. Two independent 3-bit selectors each pick one stream. One selector drives the main loop's phase detector and the other drives the auxiliary loop's phase detector.

The counter runs while at least one loop is enabled. When both loops are disabled, the whole divider is cleared. When a loop is enabled again, the divider restarts from a known state, so the first comparison edge falls a fixed number of cycles after wake-up and not at a random phase. The outputs are single-cycle strobes for the phase detectors. They have no valid/ready handshake, because a strobe cannot be held back without shifting the loop phase, so no back-pressure applies.

Top module: `refdiv_top`

## Requirements
- R1: While `rst_n` is low, both `pulse_main` and `pulse_aux` are low.
- R2: With select code 000, an enabled output pulses every R cycles, and each pulse lasts one cycle. The first pulse is visible after the R-th rising edge counted from activation.
- R3: Select code k (001 = 1 up to 100 = 4) gives a pulse every 2^k·R cycles. The first pulse is visible after the (2^k·R)-th rising edge from activation, so every deeper tap coincides with a pulse of each shallower tap.
- R4: Select codes 101, 110 and 111 behave exactly like 100, giving division by 16·R.
- R5: The main select and the auxiliary select act independently. Each output follows only its own code, and both outputs share one time base.
- R6: `r_div` is 10 bits wide. Values 0 to 3 are outside the legal range (4 to 1023) and act as 4.
- R7: The divider runs while either enable is high. A disabled loop's output stays low, and the other loop's pulse timing is not disturbed.
- R8: While both enables are low, the divider is cleared and both outputs stay low. On re-enable it restarts from zero, and neither output pulses in the first cycle after wake-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| r_div | input | 10 | Divide-by-R value |
| sel_main | input | 3 | Tap select for the main loop |
| sel_aux | input | 3 | Tap select for the auxiliary loop |
| en_main | input | 1 | Main loop power-up enable |
| en_aux | input | 1 | Auxiliary loop power-up enable |
| pulse_main | output | 1 | Comparison strobe for the main phase detector |
| pulse_aux | output | 1 | Comparison strobe for the auxiliary phase detector |

## Verification
The assertions assume that reset is applied before use. They also assume that `r_div` changes only while both enables are low, so that each pulse train has a steady period. The selects and the individual enables may change on any cycle. The stimulus changes R only inside a power-down gap of at least one cycle. It otherwise switches select codes, including the codes above 100, and toggles one enable at a time while the other loop keeps running.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  parameter int REF_W  = 10;  // width of the R field
  parameter int N_TAPS = 5;   // R, 2R, 4R, 8R, 16R
  parameter int SEL_W  = 3;   // tap select width
  parameter int R_MIN  = 4;   // smallest legal R
endpackage

// File: rtl/refdiv_count.sv
module refdiv_count
  import refdiv_pkg::*;
#(
  parameter int RW   = REF_W,
  parameter int RMIN = R_MIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [RW-1:0] r_val,
  output logic          tc
);
  localparam logic [RW-1:0] RMIN_V = RW'(RMIN);

  logic [RW-1:0] cnt;
  logic [RW-1:0] r_eff;
  logic [RW-1:0] last;

  // illegal small ratios fall back to the minimum
  assign r_eff = (r_val < RMIN_V) ? RMIN_V : r_val;
  assign last  = r_eff - RW'(1);
  // >= keeps the count bounded even if R shrinks mid-count
  assign tc    = run && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tc)     cnt <= '0;
    else             cnt <= cnt + RW'(1);
  end
endmodule

// File: rtl/refdiv_post.sv
module refdiv_post
  import refdiv_pkg::*;
#(
  parameter int NT = N_TAPS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tc,
  output logic [NT-1:0] taps
);
  localparam int PW = (NT > 1) ? NT - 1 : 1;

  logic [PW-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stage <= '0;
    else if (!run) stage <= '0;
    else if (tc)   stage <= stage + PW'(1);
  end

  assign taps[0] = tc;
  generate
    for (genvar k = 1; k < NT; k++) begin : g_tap
      // tap k fires on the terminal count that completes 2^k ratios
      assign taps[k] = tc && (&stage[k-1:0]);
    end
  endgenerate
endmodule

// File: rtl/refdiv_tapsel.sv
module refdiv_tapsel
  import refdiv_pkg::*;
#(
  parameter int NT = N_TAPS,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [SW-1:0] sel,
  input  logic [NT-1:0] taps,
  output logic          pulse
);
  localparam logic [SW-1:0] TOP = SW'(NT - 1);

  logic [SW-1:0] idx;
  assign idx = (sel > TOP) ? TOP : sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= en && taps[idx];
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top
  import refdiv_pkg::*;
#(
  parameter int RW = REF_W,
  parameter int NT = N_TAPS,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] r_div,
  input  logic [SW-1:0] sel_main,
  input  logic [SW-1:0] sel_aux,
  input  logic          en_main,
  input  logic          en_aux,
  output logic          pulse_main,
  output logic          pulse_aux
);
  logic          run;
  logic          tc;
  logic [NT-1:0] taps;

  assign run = en_main | en_aux;

  refdiv_count #(.RW(RW), .RMIN(R_MIN)) u_count (
    .clk(clk), .rst_n(rst_n), .run(run), .r_val(r_div), .tc(tc)
  );

  refdiv_post #(.NT(NT)) u_post (
    .clk(clk), .rst_n(rst_n), .run(run), .tc(tc), .taps(taps)
  );

  refdiv_tapsel #(.NT(NT), .SW(SW)) u_sel_main (
    .clk(clk), .rst_n(rst_n), .en(en_main), .sel(sel_main),
    .taps(taps), .pulse(pulse_main)
  );

  refdiv_tapsel #(.NT(NT), .SW(SW)) u_sel_aux (
    .clk(clk), .rst_n(rst_n), .en(en_aux), .sel(sel_aux),
    .taps(taps), .pulse(pulse_aux)
  );
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk
  import refdiv_pkg::*;
#(
  parameter int RW = REF_W,
  parameter int NT = N_TAPS,
  parameter int SW = SEL_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] r_div,
  input logic [SW-1:0] sel_main,
  input logic [SW-1:0] sel_aux,
  input logic          en_main,
  input logic          en_aux,
  input logic          pulse_main,
  input logic          pulse_aux
);
  localparam logic [SW-1:0] TOP = SW'(NT - 1);

  logic [SW-1:0] em, ea;
  logic          awake;
  assign em    = (sel_main > TOP) ? TOP : sel_main;
  assign ea    = (sel_aux  > TOP) ? TOP : sel_aux;
  assign awake = en_main || en_aux;

  always_comb begin
    if (!rst_n) assert (!pulse_main && !pulse_aux);  // R1
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> (!pulse_main && !pulse_aux));  // R8
  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awake) |=> (!pulse_main && !pulse_aux));  // R8
  AST_MAIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_main |=> !pulse_main);  // R7
  AST_AUX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_aux |=> !pulse_aux);  // R7
  AST_MAIN_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_main |=> !pulse_main);  // R2
  AST_AUX_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_aux |=> !pulse_aux);  // R2
  AST_SAME_TAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (en_main && en_aux && em == ea) |=> (pulse_main == pulse_aux));  // R4
endmodule

bind refdiv_top refdiv_chk #(.RW(RW), .NT(NT), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .r_div(r_div), .sel_main(sel_main),
  .sel_aux(sel_aux), .en_main(en_main), .en_aux(en_aux),
  .pulse_main(pulse_main), .pulse_aux(pulse_aux)
);

// File: tb/test_refdiv_top.sv
`timescale 1ns/1ps
module test_refdiv_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] r_div;
  logic [2:0] sel_main, sel_aux;
  logic       en_main, en_aux;
  logic       pulse_main, pulse_aux;

  int n_cmp = 0;
  int n_bad = 0;
  int edges = 0;      // rising edges since activation
  int cyc = 0;
  bit exp_m = 1'b0, exp_a = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  refdiv_top i_refdiv_top (
    .clk(clk), .rst_n(rst_n), .r_div(r_div), .sel_main(sel_main),
    .sel_aux(sel_aux), .en_main(en_main), .en_aux(en_aux),
    .pulse_main(pulse_main), .pulse_aux(pulse_aux)
  );

  function automatic int eff_r(input logic [9:0] r);
    return (r < 10'd4) ? 4 : int'(r);
  endfunction

  function automatic int eff_sel(input logic [2:0] s);
    return (s > 3'd4) ? 4 : int'(s);
  endfunction

  function automatic bit want(input bit en, input logic [2:0] s,
                              input logic [9:0] r, input int e);
    return en && (e % ((1 << eff_sel(s)) * eff_r(r)) == 0);
  endfunction

  function automatic string tag(input bit en, input logic [2:0] s,
                                input logic [2:0] other, input bit oen);
    if (!rst_n)                           return "R1";
    if (!en_main && !en_aux)              return "R8";
    if (!en)                              return "R7";
    if (r_div < 10'd4)                    return "R6";
    if (oen && eff_sel(s) != eff_sel(other)) return "R5";
    if (s > 3'd4)                         return "R4";
    if (s == 3'd0)                        return "R2";
    return "R3";
  endfunction

  // reference model, advanced on each rising edge (inputs are stable there)
  always @(posedge clk) begin
    cyc++;
    if (!rst_n || !(en_main || en_aux)) begin
      edges = 0; exp_m = 1'b0; exp_a = 1'b0;
    end else begin
      edges++;
      exp_m = want(en_main, sel_main, r_div, edges);
      exp_a = want(en_aux,  sel_aux,  r_div, edges);
    end
  end

  task automatic check_one(input string rq, input bit act, input bit exp_v,
                           input string nm);
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: got %0b expected %0b", rq, nm, cyc, act, exp_v);
    end
  endtask

  // compare on the falling edge, before any new input is driven
  task automatic tick();
    @(negedge clk);
    check_one(tag(en_main, sel_main, sel_aux, en_aux), pulse_main, exp_m, "pulse_main");
    check_one(tag(en_aux, sel_aux, sel_main, en_main), pulse_aux, exp_a, "pulse_aux");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic power_cycle(input logic [9:0] r, input bit m, input bit a);
    en_main = 1'b0; en_aux = 1'b0;
    tick();
    r_div = r;
    tick();
    en_main = m; en_aux = a;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d: got running expected finished", cyc);
    finish_up();
  end

  initial begin
    void'($urandom(32'd20517));
    rst_n = 1'b0; r_div = 10'd10; sel_main = 3'd0; sel_aux = 3'd0;
    en_main = 1'b1; en_aux = 1'b1;
    run(4);                             // R1 reset state checked each cycle
    rst_n = 1'b1;
    // R2: smallest legal ratio, undivided tap on both loops
    power_cycle(10'd4, 1'b1, 1'b1);
    run(100);
    // R3: every tap on main, R5: different tap on aux
    for (int k = 1; k <= 4; k++) begin
      sel_main = 3'(k); sel_aux = 3'(k - 1);
      power_cycle(10'd5, 1'b1, 1'b1);
      run(5 * 16 * 3);
    end
    // R4: codes above 100 against code 100
    sel_main = 3'd7; sel_aux = 3'd4;
    power_cycle(10'd6, 1'b1, 1'b1);
    run(400);
    sel_main = 3'd5; sel_aux = 3'd6;
    run(300);
    // R6: ratios below the legal range
    sel_main = 3'd0; sel_aux = 3'd1;
    power_cycle(10'd0, 1'b1, 1'b1);
    run(60);
    power_cycle(10'd3, 1'b1, 1'b1);
    run(60);
    // largest ratio
    sel_main = 3'd0; sel_aux = 3'd1;
    power_cycle(10'd1023, 1'b1, 1'b1);
    run(2100);
    // R7: one loop off while the other keeps its timing
    sel_main = 3'd1; sel_aux = 3'd0;
    power_cycle(10'd9, 1'b1, 1'b1);
    run(50);
    en_aux = 1'b0; run(77);
    en_aux = 1'b1; run(90);
    en_main = 1'b0; run(45);
    en_main = 1'b1; run(60);
    // R8: idle then wake up
    en_main = 1'b0; en_aux = 1'b0;
    run(30);
    en_aux = 1'b1;
    run(200);
    // constrained random
    for (int seg = 0; seg < 45; seg++) begin
      logic [9:0] r;
      int pick;
      bit m, a;
      pick = int'($urandom_range(0, 9));
      r = (pick == 0) ? 10'($urandom_range(0, 3)) : 10'($urandom_range(4, 60));
      pick = int'($urandom_range(0, 3));
      m = (pick != 1); a = (pick != 0);
      sel_main = 3'($urandom_range(0, 7));
      sel_aux  = 3'($urandom_range(0, 7));
      power_cycle(r, m, a);
      for (int j = 0; j < 6; j++) begin
        run(int'($urandom_range(40, 250)));
        pick = int'($urandom_range(0, 5));
        case (pick)
          0: sel_main = 3'($urandom_range(0, 7));
          1: sel_aux  = 3'($urandom_range(0, 7));
          2: if (en_aux)  en_main = ~en_main;
          3: if (en_main) en_aux  = ~en_aux;
          default: ;
        endcase
      end
    end
    finish_up();
  end
endmodule